// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short register of the outcomes of the most recent resolved branches. That history is joined with low-order bits of the branch address. The result selects one saturating counter out of a single flat array. The array is laid out as one row per address slice and one column per possible history pattern. The default is a two-bit history, two-bit counters and 256 rows, which gives 1024 counters.

A fetch stage drives a PC on the lookup port. It gets the direction back in the same cycle, together with the history value used to make it. It holds that history alongside the branch. When the branch resolves, it sends back the PC, the held history and the real outcome on the update port. That exact counter is then trained, and the outcome is shifted into the history. No tags are kept, so branches whose low address bits match share counters.

Top module: `corr_bpred`

## Requirements
- R1: While `rst` is high at a clock edge, every counter is set to the value just below the taken threshold (binary 01 for two-bit counters), and the history clears to zero. So after reset every lookup predicts not-taken and `lk_hist` reads 0.
- R2: `lk_taken` is 1 exactly when the selected counter is at least 2^(CTR_W-1), which is its most significant bit.
- R3: A valid update with `up_taken`=1 raises the selected counter by one. It stays at 2^CTR_W-1 once there.
- R4: A valid update with `up_taken`=0 lowers the selected counter by one. It stays at 0 once there.
- R5: On each valid update the history shifts left by one place. `up_taken` enters bit 0, and the oldest bit drops out.
- R6: The counter is selected by the concatenation {PC[PC_LSB+ADDR_BITS-1:PC_LSB], history}. The address slice is the row and the history is the column. For a lookup, the history is the internal register. For an update, it is `up_hist`. Only that one counter changes, and the other history columns of the same row keep their values.
- R7: Two PCs that agree in bits [PC_LSB+ADDR_BITS-1:PC_LSB] share the same counters. No tag check is made.
- R8: Lookup is combinational. An update becomes visible from the next clock edge. A lookup of the entry being updated in the same cycle returns the old value.
- R9: When `up_valid` is low, the update fields are ignored. No counter changes and the history holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | History used for this lookup, to be returned with the update |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History captured when that branch was predicted |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A fixed sequence drives one branch through repeated taken outcomes and then repeated not-taken outcomes. This separates correct saturation from wrap-around and off-by-one thresholds. A second sequence trains the same row with different returned histories, which shows that columns are independent and that the index is not taken from the address alone. A third sequence uses an aliasing PC pair and strobes that are held low, which tests the shared rows and the ignored updates. A long random mix follows, with same-cycle read/write collisions and returned histories, and a behavioural model is compared on every cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  // Saturating step for a counter up to 8 bits wide; width passed in.
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input logic up, input int unsigned w);
    int top;
    int v;
    top = (1 << w) - 1;
    v   = int'(cur);
    if (up && v < top)     v = v + 1;
    else if (!up && v > 0) v = v - 1;
    return 8'(v);
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
    end
  endgenerate

  assign hist = hist_q;
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2,
  parameter logic [CTR_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CTR_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CTR_W-1:0] rd_b_data,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [CTR_W-1:0] w_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CTR_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT;
    end else if (we) begin
      cells[w_idx] <= w_data;
    end
  end

  assign rd_a_data = cells[rd_a_idx];
  assign rd_b_data = cells[rd_b_idx];
endmodule

// File: rtl/bp_sat_update.sv
module bp_sat_update #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             taken,
  output logic [CTR_W-1:0] nxt
);
  import bpred_pkg::*;
  logic [7:0] wide;

  always_comb begin
    wide = sat_step(8'(cur), taken, CTR_W);
    nxt  = wide[CTR_W-1:0];
  end
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int ADDR_BITS = 8,
  parameter int HIST_W    = 2,
  parameter int CTR_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken
);
  localparam int IDX_W = ADDR_BITS + HIST_W;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [CTR_W-1:0]  lk_ctr, up_old, up_new;
  logic              tab_we;

  assign lk_idx = {lk_pc[PC_LSB +: ADDR_BITS], ghr};
  assign up_idx = {up_pc[PC_LSB +: ADDR_BITS], up_hist};
  assign tab_we = up_valid;

  bp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst(rst), .shift_en(up_valid), .bit_in(up_taken), .hist(ghr)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .INIT(WEAK_NT)) u_tab (
    .clk(clk), .rst(rst),
    .rd_a_idx(lk_idx), .rd_a_data(lk_ctr),
    .rd_b_idx(up_idx), .rd_b_data(up_old),
    .we(tab_we), .w_idx(up_idx), .w_data(up_new)
  );

  bp_sat_update #(.CTR_W(CTR_W)) u_upd (
    .cur(up_old), .taken(up_taken), .nxt(up_new)
  );

  assign lk_taken = lk_ctr[CTR_W-1];
  assign lk_hist  = ghr;
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [HIST_W-1:0] lk_hist,
  input logic              up_valid,
  input logic              up_taken,
  input logic              tab_we,
  input logic [CTR_W-1:0]  tab_old,
  input logic [CTR_W-1:0]  tab_new
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  a_r1_hist_clear: assert property (@(posedge clk) rst |=> lk_hist == '0);

  a_r5_hist_shift: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

  a_r9_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(lk_hist));

  a_r3_inc: assert property (@(posedge clk) disable iff (rst)
    (tab_we && up_taken && tab_old != CMAX) |-> tab_new == tab_old + 1'b1);

  a_r3_sat_top: assert property (@(posedge clk) disable iff (rst)
    (tab_we && up_taken && tab_old == CMAX) |-> tab_new == CMAX);

  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (tab_we && !up_taken && tab_old != '0) |-> tab_new == tab_old - 1'b1);

  a_r4_sat_bottom: assert property (@(posedge clk) disable iff (rst)
    (tab_we && !up_taken && tab_old == '0) |-> tab_new == '0);
endmodule

bind corr_bpred bpred_chk #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_hist(lk_hist), .up_valid(up_valid),
  .up_taken(up_taken), .tab_we(tab_we), .tab_old(up_old), .tab_new(up_new)
);

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [1:0]  lk_hist;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [1:0]  up_hist = '0;
  logic        up_taken = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int mc [1024];
  int mh;

  always #2 clk = ~clk;

  corr_bpred u_dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
  );

  function automatic int key(input logic [31:0] pc, input int h);
    return int'((pc >> 2) & 32'd255) * 4 + h;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) mc[i] = 1;
    mh = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance the model at posedge.
  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input int uh, input bit ut, input string req);
    int exp_t;
    int k;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_hist = 2'(uh); up_taken = ut;
    #1;
    exp_t = (mc[key(lpc, mh)] >= 2) ? 1 : 0;
    chk(int'(lk_taken) == exp_t, {req, " prediction"}, int'(lk_taken), exp_t);
    chk(int'(lk_hist) == mh, {req, " history"}, int'(lk_hist), mh);
    @(posedge clk);
    if (uv) begin
      k = key(upc, uh);
      if (ut && mc[k] < 3) mc[k]++;
      else if (!ut && mc[k] > 0) mc[k]--;
      mh = ((mh << 1) | int'(ut)) & 3;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb;
    logic [31:0] pool [6];
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, several addresses
    step(32'h0000_0000, 0, 0, 0, 0, "R1");
    step(32'h0000_0404, 0, 0, 0, 0, "R1");
    step(32'h0000_03FC, 0, 0, 0, 0, "R1");

    pa = 32'h0000_1040;
    pb = pa + 32'h0000_0400;   // same bits [9:2]: alias
    // R3/R2: train column 0 of pa upward past saturation; R8 same-cycle read
    for (int i = 0; i < 5; i++) step(pa, 1, pa, 0, 1, "R3 R8");
    // history now 3; train column 3 of pa so lookups at hist 3 see it
    step(pa, 1, pa, 3, 1, "R2 R6");
    step(pa, 1, pa, 3, 1, "R2 R6");
    step(pa, 0, 0, 0, 0, "R2 R8");
    // R7: alias shares counters
    step(pb, 0, 0, 0, 0, "R7");
    // R4: drive column 3 down past zero
    for (int i = 0; i < 5; i++) step(pa, 1, pa, 3, 0, "R4");
    // R6: column 0 untouched by column 3 training
    step(pa, 1, pa, 0, 1, "R6");
    step(pa, 1, pa, 0, 1, "R6");
    step(pa, 0, 0, 0, 0, "R6");
    // R9: strobe low with live-looking fields
    for (int i = 0; i < 4; i++) step(pa, 0, pa, 0, i[0], "R9");
    // R5: history sequence 1,0,1,1
    step(pb, 1, 32'h10, 1, 1, "R5");
    step(pb, 1, 32'h10, 1, 0, "R5");
    step(pb, 1, 32'h10, 1, 1, "R5");
    step(pb, 1, 32'h10, 1, 1, "R5");
    step(pb, 0, 0, 0, 0, "R5");

    // Random mix with collisions and returned histories
    pool[0] = pa; pool[1] = pb; pool[2] = 32'h0000_2008;
    pool[3] = 32'h0000_2408; pool[4] = 32'h0000_00F0; pool[5] = 32'h0000_3FFC;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] l, u;
      int h;
      l = pool[$urandom_range(0, 5)];
      u = ($urandom_range(0, 3) == 0) ? l : pool[$urandom_range(0, 5)];
      h = ($urandom_range(0, 1) == 0) ? mh : $urandom_range(0, 3);
      step(l, ($urandom_range(0, 3) != 0), u, h, $urandom_range(0, 1) != 0, "R2 R3 R4 R6 R8 mix");
    end

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1; up_valid = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 1'b0;
    step(pa, 0, 0, 0, 0, "R1 rerun");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule